// File: doc/BRIEF.md
# Programmable Octet-Granular Video Timing Generator

This block produces the raster timing for a bit-plane video display. Every clock is one pixel. Eight pixels form an octet, and horizontal timing is programmed in octets. Each scan line passes through four phases in a fixed order: sync, then back blanking with the left border, then the visible screen, then the right border with front blanking. Vertical timing uses the same four-phase order, counted in scan lines. A small register file sets the length of every phase.

The block outputs horizontal and vertical sync, a screen-active flag and a video memory byte address. The address reloads from a programmable start address at every frame start, which gives hardware scrolling. It then advances by one for each octet shown on screen. Its wrap point follows the plane size chosen by the display mode. The screen height register holds only eight bits. The two larger display modes add an implicit high bit to it. A three-bit fine delay shifts horizontal sync by whole pixels. A frame interrupt is raised when vertical sync begins and is cleared by a read of the mode register.

Top module: `vtg_core`

## Requirements
- R1: A line runs sync, back, screen and front phases in that order. Each phase lasts 8 times the value written with `tim_wr` at `tim_idx` = {phase, 0}, where the phase code is 0 sync, 1 back, 2 screen, 3 front. The horizontal sync pulse, the line period and each active run follow from these values.
- R2: A frame runs the same four phases in lines, programmed at `tim_idx` = {phase, 1}. Vertical sync lasts its value in lines, and the number of active runs per frame equals the screen height.
- R3: The mode register (`io_wr` at `io_idx` 0) carries the display mode in bits 1:0. The screen height is the 8-bit value plus 256 in mode 2, and plus 512 in mode 3.
- R4: A phase length of 0 acts as a length of 1.
- R5: Mode register bits 7:5 delay horizontal sync by 0 to 7 pixels. The pulse width does not change, and vertical sync is not delayed.
- R6: `irq` goes high in the cycle vertical sync begins. It stays high until a `mode_rd` pulse, and is low from the cycle after that pulse.
- R7: At each frame start, `vaddr` loads the start address. The start address is written at `io_idx` 2 (low byte) and `io_idx` 3 (high byte), and is masked to the plane size.
- R8: `vaddr` advances by one after each active octet and holds at all other times. It carries over from line to line, so the last active octet of a frame shows start + width × height − 1.
- R9: Display modes 0, 1, 2 and 3 select planes of 8, 16, 32 and 64 KB. The address wraps to 0 past the end of the plane.
- R10: A length written while a phase runs takes effect at the next entry to that phase. The current phase keeps its length.
- R11: With `sync_pol_high` = 1 the sync outputs are active high. With 0 they are active low.
- R12: After reset, both axes sit in their sync phase, `active` and `irq` are 0, and `vaddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_wr | input | 1 | Timing register write strobe |
| tim_idx | input | 3 | Timing register select: bit 0 axis (0 horizontal), bits 2:1 phase |
| io_wr | input | 1 | Control register write strobe |
| io_idx | input | 2 | Control register select: 0 mode, 2 start low, 3 start high |
| wdata | input | 8 | Write data |
| mode_rd | input | 1 | Pulse marking a read of the mode register |
| sync_pol_high | input | 1 | 1 selects active-high sync outputs |
| hsync | output | 1 | Horizontal sync, fine delayed |
| vsync | output | 1 | Vertical sync |
| active | output | 1 | High while both axes are in the screen phase |
| vaddr | output | 16 | Video memory byte address |
| irq | output | 1 | Frame interrupt |

## Verification
The phase state, `vaddr` and `irq` are registered. They change one edge after the cycle that causes them, so `irq` and `vsync` rise together, and `hsync` follows `vsync` by exactly the fine delay in pixels. Register writes apply only at the next entry to a phase. For this reason the bench waits one full frame start after any configuration change before it measures. The bench samples at the falling clock edge and measures durations as counts of cycles between edges. Fixed register latency therefore cancels out, and each expected width, period, line count and address follows directly from the programmed lengths.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int PIX_PER_OCT = 8;
  localparam int OCT_W       = 3;
  localparam int H_W         = 8;
  localparam int V_W         = 10;
  localparam int A_W         = 16;
  localparam int DLY_MAX     = 7;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_SCREEN = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  // Effective vertical screen height: the 8-bit low part plus an implicit high bit.
  function automatic logic [V_W-1:0] screen_lines(input logic [7:0] low,
                                                  input logic [1:0] mode);
    logic [V_W-1:0] h;
    case (mode)
      2'd2:    h = {2'b01, low};
      2'd3:    h = {2'b10, low};
      default: h = {2'b00, low};
    endcase
    return h;
  endfunction

  // Byte mask for the plane: 8 KB shifted left by the mode, minus one.
  function automatic logic [A_W-1:0] plane_mask(input logic [1:0] mode);
    logic [A_W:0] sz;
    sz = (A_W+1)'(17'h02000) << mode;
    return A_W'(sz - 1'b1);
  endfunction

  // Downcounter preload for a phase; a zero length acts as one unit.
  function automatic logic [V_W-1:0] preload(input logic [V_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int HW = H_W,
  parameter int VW = V_W,
  parameter int AW = A_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tim_wr,
  input  logic [2:0]          tim_idx,
  input  logic                io_wr,
  input  logic [1:0]          io_idx,
  input  logic [7:0]          wdata,
  output logic [3:0][HW-1:0]  h_len,
  output logic [3:0][VW-1:0]  v_len,
  output logic [2:0]          fine_dly,
  output logic [AW-1:0]       start_addr,
  output logic [AW-1:0]       addr_mask
);

  logic [3:0][7:0] h_raw;
  logic [3:0][7:0] v_raw;
  logic [1:0]      mode_q;
  logic [7:0]      start_lo;
  logic [7:0]      start_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_raw    <= '0;
      v_raw    <= '0;
      mode_q   <= 2'd0;
      fine_dly <= 3'd0;
      start_lo <= 8'h00;
      start_hi <= 8'h00;
    end else begin
      if (tim_wr) begin
        if (tim_idx[0]) v_raw[tim_idx[2:1]] <= wdata;
        else            h_raw[tim_idx[2:1]] <= wdata;
      end
      if (io_wr) begin
        case (io_idx)
          2'd0: begin
            mode_q   <= wdata[1:0];
            fine_dly <= wdata[7:5];
          end
          2'd2:    start_lo <= wdata;
          2'd3:    start_hi <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_len
    assign h_len[i] = HW'(h_raw[i]);
    if (i == int'(PH_SCREEN)) begin : g_height
      assign v_len[i] = VW'(screen_lines(v_raw[i], mode_q));
    end else begin : g_plain
      assign v_len[i] = VW'(v_raw[i]);
    end
  end

  assign start_addr = AW'({start_hi, start_lo}) & addr_mask;
  assign addr_mask  = AW'(plane_mask(mode_q));

endmodule

// File: rtl/vtg_seq.sv
module vtg_seq
  import vtg_pkg::*;
#(
  parameter int W = V_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [3:0][W-1:0]  len,
  output logic [1:0]         phase,
  output logic               boundary,
  output logic               wrap
);

  logic [W-1:0] left;
  logic [1:0]   nxt;
  logic [W-1:0] nxt_len;

  assign nxt      = phase + 2'd1;
  assign nxt_len  = len[nxt];
  assign boundary = step && (left == '0);
  assign wrap     = boundary && (phase == PH_FRONT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      left  <= '0;
    end else if (boundary) begin
      phase <= nxt;
      left  <= (nxt_len == '0) ? '0 : nxt_len - 1'b1;
    end else if (step) begin
      left  <= left - 1'b1;
    end
  end

endmodule

// File: rtl/vtg_hdelay.sv
module vtg_hdelay
  import vtg_pkg::*;
#(
  parameter int DMAX = DLY_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [2:0] sel,
  output logic       dly
);

  logic [DMAX-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[DMAX-2:0], raw};
  end

  always_comb begin
    dly = raw;
    for (int i = 1; i <= DMAX; i++) begin
      if (int'(sel) == i) dly = hist[i-1];
    end
  end

endmodule

// File: rtl/vtg_addr.sv
module vtg_addr
  import vtg_pkg::*;
#(
  parameter int AW = A_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          adv,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)      addr <= '0;
    else if (reload) addr <= start & mask;
    else if (adv)    addr <= (addr + 1'b1) & mask;
  end

endmodule

// File: rtl/vtg_core.sv
module vtg_core
  import vtg_pkg::*;
#(
  parameter int HW = H_W,
  parameter int VW = V_W,
  parameter int AW = A_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tim_wr,
  input  logic [2:0]    tim_idx,
  input  logic          io_wr,
  input  logic [1:0]    io_idx,
  input  logic [7:0]    wdata,
  input  logic          mode_rd,
  input  logic          sync_pol_high,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic [AW-1:0] vaddr,
  output logic          irq
);

  localparam logic [OCT_W-1:0] OCT_LAST = OCT_W'(PIX_PER_OCT - 1);

  logic [3:0][HW-1:0] h_len;
  logic [3:0][VW-1:0] v_len;
  logic [2:0]         fine_dly;
  logic [AW-1:0]      start_addr;
  logic [AW-1:0]      addr_mask;

  logic [OCT_W-1:0]   pix_cnt;
  logic               octet_end;
  logic [1:0]         hphase;
  logic [1:0]         vphase;
  logic               h_bound;
  logic               h_wrap;
  logic               v_bound;
  logic               frame_start;
  logic               hs_raw;
  logic               hs_dly;
  logic               adv;

  vtg_regs #(.HW(HW), .VW(VW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tim_wr     (tim_wr),
    .tim_idx    (tim_idx),
    .io_wr      (io_wr),
    .io_idx     (io_idx),
    .wdata      (wdata),
    .h_len      (h_len),
    .v_len      (v_len),
    .fine_dly   (fine_dly),
    .start_addr (start_addr),
    .addr_mask  (addr_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pix_cnt <= '0;
    else        pix_cnt <= pix_cnt + 1'b1;
  end
  assign octet_end = (pix_cnt == OCT_LAST);

  vtg_seq #(.W(HW)) u_hseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (octet_end),
    .len      (h_len),
    .phase    (hphase),
    .boundary (h_bound),
    .wrap     (h_wrap)
  );

  vtg_seq #(.W(VW)) u_vseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (h_wrap),
    .len      (v_len),
    .phase    (vphase),
    .boundary (v_bound),
    .wrap     (frame_start)
  );

  assign hs_raw = (hphase == PH_SYNC);

  vtg_hdelay #(.DMAX(DLY_MAX)) u_hdly (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (hs_raw),
    .sel   (fine_dly),
    .dly   (hs_dly)
  );

  assign active = (hphase == PH_SCREEN) && (vphase == PH_SCREEN);
  assign adv    = active && octet_end;

  vtg_addr #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (frame_start),
    .adv    (adv),
    .start  (start_addr),
    .mask   (addr_mask),
    .addr   (vaddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           irq <= 1'b0;
    else if (frame_start) irq <= 1'b1;
    else if (mode_rd)     irq <= 1'b0;
  end

  assign hsync = sync_pol_high ? hs_dly : ~hs_dly;
  assign vsync = sync_pol_high ? (vphase == PH_SYNC) : (vphase != PH_SYNC);

endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          mode_rd,
  input logic          irq,
  input logic          adv,
  input logic          h_bound,
  input logic          v_bound,
  input logic [1:0]    hphase,
  input logic [1:0]    vphase,
  input logic [AW-1:0] vaddr,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] addr_mask
);

  p_hphase_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    h_bound |=> hphase == 2'($past(hphase) + 2'd1));

  p_hphase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !h_bound |=> $stable(hphase));

  p_vphase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_bound |=> vphase == 2'($past(vphase) + 2'd1));

  p_frame_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (hphase == 2'd0) && (vphase == 2'd0));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> irq);

  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd && !frame_start |=> !irq);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !mode_rd |=> irq);

  p_addr_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> vaddr == ($past(start_addr) & $past(addr_mask)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> vaddr == AW'(($past(vaddr) + 1'b1) & $past(addr_mask)));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !frame_start |=> $stable(vaddr));

endmodule

bind vtg_core vtg_core_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .mode_rd     (mode_rd),
  .irq         (irq),
  .adv         (adv),
  .h_bound     (h_bound),
  .v_bound     (v_bound),
  .hphase      (hphase),
  .vphase      (vphase),
  .vaddr       (vaddr),
  .start_addr  (start_addr),
  .addr_mask   (addr_mask)
);

// File: tb/vtg_core_test.sv
module vtg_core_test;

  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tim_wr = 1'b0;
  logic [2:0]  tim_idx = 3'd0;
  logic        io_wr = 1'b0;
  logic [1:0]  io_idx = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic        mode_rd = 1'b0;
  logic        pol = 1'b1;
  logic        hsync, vsync, active, irq;
  logic [15:0] vaddr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  vtg_core uut (
    .clk(clk), .rst_n(rst_n), .tim_wr(tim_wr), .tim_idx(tim_idx),
    .io_wr(io_wr), .io_idx(io_idx), .wdata(wdata), .mode_rd(mode_rd),
    .sync_pol_high(pol), .hsync(hsync), .vsync(vsync), .active(active),
    .vaddr(vaddr), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic sig(input int k);
    case (k)
      0:       return pol ? hsync : ~hsync;
      1:       return pol ? vsync : ~vsync;
      default: return active;
    endcase
  endfunction

  task automatic wr_tim(input int axis, input int ph, input int val);
    @(negedge clk);
    tim_wr = 1'b1; tim_idx = 3'((ph << 1) | axis); wdata = 8'(val);
    @(negedge clk);
    tim_wr = 1'b0;
  endtask

  task automatic wr_io(input int idx, input int val);
    @(negedge clk);
    io_wr = 1'b1; io_idx = 2'(idx); wdata = 8'(val);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_h(input int a, input int b, input int c, input int d);
    wr_tim(0, 0, a); wr_tim(0, 1, b); wr_tim(0, 2, c); wr_tim(0, 3, d);
  endtask

  task automatic set_v(input int a, input int b, input int c, input int d);
    wr_tim(1, 0, a); wr_tim(1, 1, b); wr_tim(1, 2, c); wr_tim(1, 3, d);
  endtask

  task automatic set_start(input int s);
    wr_io(2, s & 8'hFF); wr_io(3, (s >> 8) & 8'hFF);
  endtask

  task automatic wait_rise(input int k);
    logic p, c;
    c = sig(k);
    do begin
      p = c;
      @(negedge clk);
      c = sig(k);
    end while (!(c && !p));
  endtask

  task automatic pulse_len(input int k, output int n);
    wait_rise(k);
    n = 0;
    while (sig(k)) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic period(input int k, output int n);
    logic p, c;
    wait_rise(k);
    n = 0;
    c = 1'b1;
    do begin
      p = c;
      @(negedge clk);
      n++;
      c = sig(k);
    end while (!(c && !p));
  endtask

  // From one vsync rise to the next: count active runs, note first and last address.
  task automatic frame_scan(output int runs, output int first, output int last);
    logic pa, pv, cv;
    bit seen;
    wait_rise(1);
    runs = 0; first = -1; last = -1; seen = 0;
    pa = active; cv = 1'b1;
    if (active) begin runs = 1; first = vaddr; last = vaddr; seen = 1; end
    do begin
      pv = cv;
      @(negedge clk);
      cv = sig(1);
      if (!(cv && !pv)) begin
        if (active && !pa) runs++;
        if (active) begin
          if (!seen) begin first = vaddr; seen = 1; end
          last = vaddr;
        end
      end
      pa = active;
    end while (!(cv && !pv));
  endtask

  task automatic config_base();
    set_h(2, 3, 4, 1);
    set_v(1, 2, 3, 1);
    wr_io(0, 8'h00);
    set_start(16'h0100);
    wait_rise(1);
  endtask

  task automatic t_reset();
    check(sig(0) == 1'b1, "R12 hsync in sync after reset", int'(sig(0)), 1);
    check(sig(1) == 1'b1, "R12 vsync in sync after reset", int'(sig(1)), 1);
    check(active == 1'b0, "R12 active low after reset", int'(active), 0);
    check(irq == 1'b0, "R12 irq low after reset", int'(irq), 0);
    check(vaddr == 16'h0, "R12 vaddr zero after reset", int'(vaddr), 0);
  endtask

  task automatic t_line_frame();
    int n, r, f, l;
    config_base();
    pulse_len(0, n); check(n == 16, "R1 hsync width", n, 16);
    period(0, n);    check(n == 80, "R1 line period", n, 80);
    pulse_len(2, n); check(n == 32, "R1 active run width", n, 32);
    pulse_len(1, n); check(n == 80, "R2 vsync width", n, 80);
    frame_scan(r, f, l);
    check(r == 3, "R2 active lines per frame", r, 3);
    check(f == 16'h0100, "R7 first address of frame", f, 16'h0100);
    check(l == 16'h010B, "R8 last address of frame", l, 16'h010B);
  endtask

  task automatic t_wrap();
    int r, f, l;
    set_start(16'hFFFE);
    wr_io(0, 8'h00);
    wait_rise(1);
    frame_scan(r, f, l);
    check(f == 16'h1FFE, "R9 mode0 masked start", f, 16'h1FFE);
    check(l == 16'h0009, "R9 mode0 wrap", l, 16'h0009);
    wr_io(0, 8'h01);
    wait_rise(1);
    frame_scan(r, f, l);
    check(f == 16'h3FFE, "R9 mode1 masked start", f, 16'h3FFE);
    check(l == 16'h0009, "R9 mode1 wrap", l, 16'h0009);
    wr_io(0, 8'h00);
    set_start(16'h0100);
  endtask

  task automatic t_delay();
    int n, off;
    for (int d = 0; d < 8; d += 3) begin
      wr_io(0, (d << 5));
      wait_rise(1);
      wait_rise(1);
      off = 0;
      while (!sig(0)) begin
        off++;
        @(negedge clk);
      end
      check(off == d, "R5 hsync offset from vsync", off, d);
    end
    wr_io(0, 8'hE0);
    wait_rise(1);
    pulse_len(0, n);
    check(n == 16, "R5 delayed hsync width", n, 16);
    wait_rise(1);
    off = 0;
    while (!sig(0)) begin off++; @(negedge clk); end
    check(off == 7, "R5 max delay", off, 7);
    wr_io(0, 8'h00);
  endtask

  task automatic t_zero();
    int n, r, f, l;
    wr_tim(0, 1, 0);
    wr_tim(1, 2, 0);
    wait_rise(1);
    period(0, n);
    check(n == 64, "R4 zero back phase acts as one octet", n, 64);
    frame_scan(r, f, l);
    check(r == 1, "R4 zero height acts as one line", r, 1);
    wr_tim(0, 1, 3);
    wr_tim(1, 2, 3);
  endtask

  task automatic t_irq();
    wait_rise(1);
    check(irq == 1'b1, "R6 irq with vsync start", int'(irq), 1);
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R6 irq held", int'(irq), 1);
    mode_rd = 1'b1;
    @(negedge clk);
    mode_rd = 1'b0;
    check(irq == 1'b0, "R6 irq cleared by read", int'(irq), 0);
    repeat (100) @(negedge clk);
    check(irq == 1'b0, "R6 irq stays cleared", int'(irq), 0);
    wait_rise(1);
    check(irq == 1'b1, "R6 irq next frame", int'(irq), 1);
  endtask

  task automatic t_defer();
    int n;
    logic a;
    set_h(1, 1, 20, 1);
    wait_rise(1);
    wait_rise(2);
    tim_wr = 1'b1; tim_idx = 3'd4; wdata = 8'd2;
    n = 1;
    @(negedge clk);
    tim_wr = 1'b0;
    a = active;
    while (a) begin
      n++;
      @(negedge clk);
      a = active;
    end
    check(n == 160, "R10 running screen phase keeps length", n, 160);
    pulse_len(2, n);
    check(n == 16, "R10 new length on next entry", n, 16);
    set_h(2, 3, 4, 1);
  endtask

  task automatic t_height();
    int r, f, l;
    set_h(1, 1, 1, 1);
    set_v(1, 1, 3, 1);
    wr_io(0, 8'h02);
    wait_rise(1);
    frame_scan(r, f, l);
    check(r == 259, "R3 mode2 implicit ninth bit", r, 259);
    wr_io(0, 8'h03);
    wait_rise(1);
    frame_scan(r, f, l);
    check(r == 515, "R3 mode3 implicit tenth bit", r, 515);
    wr_io(0, 8'h00);
  endtask

  task automatic t_polarity();
    int n;
    pol = 1'b0;
    config_base();
    pulse_len(0, n);
    check(n == 16, "R11 active-low hsync width", n, 16);
    wait_rise(2);
    check(hsync == 1'b1 && vsync == 1'b1, "R11 idle level high when active low",
          int'({hsync, vsync}), 3);
    pol = 1'b1;
    @(negedge clk);
    check(hsync == 1'b0 && vsync == 1'b0, "R11 idle level low when active high",
          int'({hsync, vsync}), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_frame();
    t_irq();
    t_wrap();
    t_delay();
    t_zero();
    t_defer();
    t_polarity();
    t_height();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule